// File: doc/BRIEF.md
# Slave Input Port Follower

This block sits on the input side of the slave half of a speed-expanded switch pair. It makes no decisions of its own. At every expected start of packet the master device hands it a command, and the command says what to do with the slave's own slice of the incoming byte stream. The packet may be an idle packet whose trailer byte must be CRC-checked. It may be an idle packet whose check must be skipped, because the master saw a header parity error on its side. It may be a data packet to throw away. It may be a data packet to write into packet memory at an address the master supplies.

The slave reports only the trailer CRC errors it detects itself. Header parity is the master's business and has no input here. Each CRC error pulses a local interrupt for one cycle and bumps a saturating error counter. The pulse reaches the main interrupt only when the mask input is low.

The controller has four states. WAIT is reached from reset and after every trailer byte; it leaves on a command strobe. CHECK is entered on code 00 and runs a CRC over the bytes before the trailer, then compares the result with the trailer. DISCARD is entered on codes 01 and 11 and consumes bytes with no effect. STORE is entered on code 10 and issues one memory write for each byte. Each of CHECK, DISCARD and STORE returns to WAIT on the trailer byte.

Top module: `slv_in_follower`

## Requirements
- R1: After reset the state is WAIT, the error counter is 0, and crc_irq, main_irq and mem_wr_en are low.
- R2: A cmd_valid pulse seen in WAIT selects the handling for the next packet from cmd_code. 2'b00 means idle with check, 2'b01 means invalid data (discard), 2'b10 means valid data (store), and 2'b11 means idle with the check suppressed. The packet ends on the byte flagged by in_last, and the block then returns to WAIT.
- R3: For code 00, the CRC-8 (polynomial x^8+x^2+x+1, i.e. 0x07, initial value 0, MSB first, no final XOR) is formed over the bytes before the trailer. If the trailer byte differs from it, crc_irq is high for exactly the one cycle after the trailer cycle, and the counter rises by 1 at the same time.
- R4: For code 00 with a matching trailer, crc_irq stays low and the counter does not change.
- R5: main_irq equals crc_irq while irq_mask is low, and main_irq is low while irq_mask is high.
- R6: For code 01, no memory write and no CRC error occur for any byte, including the trailer.
- R7: For code 10, every byte of the packet, trailer included, gives one write one cycle later. The write has mem_wr_data equal to the byte and mem_wr_addr equal to (cmd_addr + byte index) modulo 2^AW, with the index starting at 0.
- R8: For code 11, a wrong trailer raises no error and leaves the counter unchanged.
- R9: The error counter holds at all ones instead of wrapping.
- R10: cnt_clr sets the counter to 0 on the next cycle, and it wins over an increment in the same cycle.
- R11: Bytes that arrive in WAIT cause no write and no error. A cmd_valid pulse that arrives while a packet is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Master command strobe at start of packet |
| cmd_code | input | 2 | Packet handling code from the master |
| cmd_addr | input | AW | Packet memory base address for a stored packet |
| in_valid | input | 1 | Input byte qualifier |
| in_data | input | 8 | Input byte of this slice |
| in_last | input | 1 | Marks the trailer byte |
| irq_mask | input | 1 | Masks the CRC error from the main interrupt |
| cnt_clr | input | 1 | Clears the error counter |
| mem_wr_en | output | 1 | Packet memory write request |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | 8 | Write data |
| crc_irq | output | 1 | One-cycle CRC error interrupt |
| main_irq | output | 1 | Main interrupt (masked CRC error) |
| crc_err_cnt | output | CNT_W | Saturating CRC error counter |

## Verification
Every result is registered once after the byte that causes it. A memory write, a CRC interrupt and a counter change are all due in the cycle after their byte's clock edge. main_irq follows crc_irq in that same cycle. The bench drives each byte on a falling edge and checks its effect on the next falling edge, which comes after exactly one rising edge, before it drives the following byte. A command therefore never overlaps the check of the previous packet's trailer. The sweep covers all four codes, payload lengths 0 to 3, good and bad trailers and both mask values, and the counter width is reduced so that saturation is reached.

// File: rtl/slv_fol_pkg.sv
package slv_fol_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE_CHK  = 2'b00,
        CMD_INVALID   = 2'b01,
        CMD_STORE     = 2'b10,
        CMD_IDLE_SKIP = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        S_WAIT    = 2'b00,
        S_CHECK   = 2'b01,
        S_DISCARD = 2'b10,
        S_STORE   = 2'b11
    } state_e;

    localparam logic [7:0] CRC_POLY = 8'h07;

    // One byte through a CRC-8, MSB first.
    function automatic logic [7:0] crc8_byte(input logic [7:0] crc, input logic [7:0] d);
        logic [7:0] c;
        c = crc ^ d;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/slv_crc8_acc.sv
module slv_crc8_acc
    import slv_fol_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       step,
    input  logic [7:0] data,
    output logic [7:0] crc
);

    logic [7:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= 8'h00;
        end else if (restart) begin
            crc_q <= 8'h00;
        end else if (step) begin
            crc_q <= crc8_byte(crc_q, data);
        end
    end

    assign crc = crc_q;

    // R3: the accumulator is zero right after a restart.
    a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart) |-> crc == 8'h00);

endmodule

// File: rtl/slv_err_report.sv
module slv_err_report #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_evt,
    input  logic             cnt_clr,
    input  logic             irq_mask,
    output logic             crc_irq,
    output logic             main_irq,
    output logic [CNT_W-1:0] err_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= err_evt;
            if (cnt_clr) begin
                cnt_q <= '0;
            end else if (err_evt && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign crc_irq  = irq_q;
    assign main_irq = irq_q & ~irq_mask;
    assign err_cnt  = cnt_q;

    // R9: the counter only falls through a clear.
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < $past(cnt_q)) |-> $past(cnt_clr));

    // R3: the counter moves up by at most one and only with an error.
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > $past(cnt_q)) |-> ($past(err_evt) && cnt_q == $past(cnt_q) + 1'b1));

    // R10: a clear leaves zero.
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_clr) |-> cnt_q == '0);

    // R5: no main interrupt without a CRC interrupt.
    a_r5_main_needs_crc: assert property (@(posedge clk) disable iff (!rst_n)
        main_irq |-> crc_irq);

endmodule

// File: rtl/slv_in_follower.sv
module slv_in_follower
    import slv_fol_pkg::*;
#(
    parameter int AW    = 12,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_code,
    input  logic [AW-1:0]    cmd_addr,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             irq_mask,
    input  logic             cnt_clr,
    output logic             mem_wr_en,
    output logic [AW-1:0]    mem_wr_addr,
    output logic [7:0]       mem_wr_data,
    output logic             crc_irq,
    output logic             main_irq,
    output logic [CNT_W-1:0] crc_err_cnt
);

    state_e        state_q, state_d;
    logic          accept;
    logic          byte_end;
    logic          crc_step;
    logic          err_evt;
    logic [7:0]    crc_val;
    logic [AW-1:0] base_q, idx_q;
    logic          wr_en_q;
    logic [AW-1:0] wr_addr_q;
    logic [7:0]    wr_data_q;

    assign accept   = (state_q == S_WAIT) && cmd_valid;
    assign byte_end = in_valid && in_last;
    assign crc_step = (state_q == S_CHECK) && in_valid && !in_last;
    assign err_evt  = (state_q == S_CHECK) && byte_end && (in_data != crc_val);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_WAIT;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAIT: begin
                if (cmd_valid) begin
                    unique case (cmd_e'(cmd_code))
                        CMD_IDLE_CHK:  state_d = S_CHECK;
                        CMD_STORE:     state_d = S_STORE;
                        CMD_INVALID,
                        CMD_IDLE_SKIP: state_d = S_DISCARD;
                        default:       state_d = S_DISCARD;
                    endcase
                end
            end
            S_CHECK, S_DISCARD, S_STORE: begin
                if (byte_end) state_d = S_WAIT;
            end
            default: state_d = S_WAIT;
        endcase
    end

    // Write path outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            idx_q     <= '0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (accept) begin
                base_q <= cmd_addr;
                idx_q  <= '0;
            end else if (state_q == S_STORE && in_valid) begin
                wr_en_q   <= 1'b1;
                wr_addr_q <= base_q + idx_q;
                wr_data_q <= in_data;
                idx_q     <= idx_q + 1'b1;
            end
        end
    end

    assign mem_wr_en   = wr_en_q;
    assign mem_wr_addr = wr_addr_q;
    assign mem_wr_data = wr_data_q;

    slv_crc8_acc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .step    (crc_step),
        .data    (in_data),
        .crc     (crc_val)
    );

    slv_err_report #(.CNT_W(CNT_W)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_evt  (err_evt),
        .cnt_clr  (cnt_clr),
        .irq_mask (irq_mask),
        .crc_irq  (crc_irq),
        .main_irq (main_irq),
        .err_cnt  (crc_err_cnt)
    );

    // R7: a write only follows an input byte taken in STORE.
    a_r7_write_from_store: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(state_q) == S_STORE && $past(in_valid)));

    // R3: a CRC interrupt only follows a trailer seen in CHECK.
    a_r3_irq_from_check: assert property (@(posedge clk) disable iff (!rst_n)
        crc_irq |-> ($past(state_q) == S_CHECK && $past(in_valid) && $past(in_last)));

    // R2: every packet state returns to WAIT after the trailer.
    a_r2_back_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_WAIT && byte_end) |=> state_q == S_WAIT);

    // R11: a command during a packet leaves the state alone.
    a_r11_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_WAIT && !in_valid) |=> $stable(state_q));

endmodule

// File: tb/test_slv_in_follower.sv
module test_slv_in_follower;

    localparam int AW    = 8;
    localparam int CNT_W = 4;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_code = 2'b00;
    logic [AW-1:0]    cmd_addr = '0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = 8'h00;
    logic             in_last = 1'b0;
    logic             irq_mask = 1'b0;
    logic             cnt_clr = 1'b0;
    logic             mem_wr_en;
    logic [AW-1:0]    mem_wr_addr;
    logic [7:0]       mem_wr_data;
    logic             crc_irq;
    logic             main_irq;
    logic [CNT_W-1:0] crc_err_cnt;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;

    always #10 clk = ~clk;

    slv_in_follower #(.AW(AW), .CNT_W(CNT_W)) i_slv_in_follower (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .irq_mask(irq_mask), .cnt_clr(cnt_clr), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .crc_irq(crc_irq),
        .main_irq(main_irq), .crc_err_cnt(crc_err_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [8:0] w;
        logic [7:0] r;
        r = c ^ d;
        for (int k = 0; k < 8; k++) begin
            w = {r, 1'b0};
            r = w[8] ? (w[7:0] ^ 8'h07) : w[7:0];
        end
        return r;
    endfunction

    // One packet: command, len payload bytes, then trailer.
    task automatic run_pkt(input int code, input int base, input int len, input int seed,
                           input bit bad, input bit mask, input bit clr_end, input bit stray_cmd);
        logic [7:0] crc;
        logic [7:0] b;
        bit         err;
        crc = 8'h00;
        irq_mask  = mask;
        cmd_valid = 1'b1;
        cmd_code  = code[1:0];
        cmd_addr  = base[AW-1:0];
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i <= len; i++) begin
            if (i < len) begin
                b = 8'((seed * 37 + i * 11 + 5) & 8'hFF);
                crc = ref_crc(crc, b);
            end else begin
                b = bad ? (crc ^ 8'h5A) : crc;
            end
            in_valid = 1'b1;
            in_data  = b;
            in_last  = (i == len);
            cnt_clr  = clr_end && (i == len);
            if (stray_cmd && i == 0) begin
                cmd_valid = 1'b1;
                cmd_code  = 2'b00;
            end
            @(posedge clk); @(negedge clk);
            cmd_valid = 1'b0;
            chk("R7/R6 wr_en", mem_wr_en, code == 2);
            if (code == 2) begin
                chk("R7 wr_addr", mem_wr_addr, (base + i) % (1 << AW));
                chk("R7 wr_data", mem_wr_data, b);
            end
            err = (code == 0) && bad && (i == len);
            if (err && exp_cnt < CMAX) exp_cnt++;
            if (clr_end && i == len) exp_cnt = 0;
            chk(code == 3 ? "R8 crc_irq" : (bad ? "R3 crc_irq" : "R4 crc_irq"), crc_irq, err);
            chk("R5 main_irq", main_irq, err && !mask);
            chk(clr_end ? "R10 count" : "R9 count", crc_err_cnt, exp_cnt);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        cnt_clr  = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R3 irq one cycle", crc_irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 count", crc_err_cnt, 0);
        chk("R1 crc_irq", crc_irq, 0);
        chk("R1 main_irq", main_irq, 0);
        chk("R1 wr_en", mem_wr_en, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: bytes in WAIT do nothing
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1; in_data = 8'hA5; in_last = (i == 2);
            @(posedge clk); @(negedge clk);
            chk("R11 wait wr_en", mem_wr_en, 0);
            chk("R11 wait irq", crc_irq, 0);
        end
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);

        // R2 sweep: all codes, lengths, trailer good/bad, masks
        for (int code = 0; code < 4; code++)
            for (int len = 0; len < 4; len++)
                for (int bad = 0; bad < 2; bad++)
                    for (int m = 0; m < 2; m++)
                        run_pkt(code, 250 + len * 3 + code, len, code * 8 + len + bad,
                                bad[0], m[0], 1'b0, 1'b0);

        // R9: push counter to saturation
        for (int k = 0; k < CMAX + 3; k++) run_pkt(0, 0, 1, k, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R9 saturated", crc_err_cnt, CMAX);

        // R10: clear together with an error
        run_pkt(0, 0, 2, 7, 1'b1, 1'b0, 1'b1, 1'b0);
        run_pkt(0, 0, 2, 9, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R10 count after clear", crc_err_cnt, 1);

        // R11: stray command during a store is ignored
        run_pkt(2, 17, 3, 4, 1'b1, 1'b0, 1'b0, 1'b1);
        // R8: skip code with wrong trailer and stray command
        run_pkt(3, 0, 3, 2, 1'b1, 1'b0, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule